// File: doc/BRIEF.md
# Prioritized Interrupt Pending and Enable Controller

This block tracks up to 32 external interrupt lines for a processor core. Each line has an enable bit, a pending bit, an active bit and a byte-wide priority. Software reaches these through a word-addressed register port. Enables and pending flags each have a write view that only sets bits and another that only clears them. A software trigger word pends one line by its number. A keyed control word holds the grouping field, which splits every priority byte into a preemption level and a subpriority.

On every cycle the controller picks the most urgent line that is both pending and enabled, and presents it as a vector number. It raises a preempt request when the preemption level of that line is strictly more urgent than the running level. The running level is the most urgent level among the active lines. The core answers with an acknowledge, which moves the chosen line from pending to active. A completion strobe naming a line clears that line's active bit. A line that is disabled still latches pending but is never chosen.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Word 0 (enable-set view) sets the enable of every line whose write bit is 1, and word 1 (enable-clear view) clears it. Zero bits have no effect, bits above the line count are ignored, and both words read the enable vector.
- R2: Word 2 (pend-set view) sets pending bits and word 3 (pend-clear view) clears them, zero bits having no effect. Both words read the pending vector. A software clear of a line wins over any set of that line in the same cycle.
- R3: A high interrupt input pends its line at the next clock edge even when the line is disabled. A line that is not enabled is never selected, so with no enabled pending line `pend_valid` is 0.
- R4: Clearing the enable of an active line leaves its active bit set.
- R5: A pend-clear write to a line that is active but not pending leaves its active bit set.
- R6: Line n's priority occupies byte n%4 of word 8+n/4. Only the top PRIO_BITS bits of each byte are stored, and the lower bits read as 0. Priority 0 is the most urgent.
- R7: The selected line is the pending and enabled line with the numerically smallest priority byte, and a tie goes to the lower line number. `pend_vector` equals the line number plus 16.
- R8: With grouping value G, the preemption level of a priority is the byte with bits G..0 forced to 0. `preempt_req` is 1 when a line is selected and either no line is active or the selected level is strictly below the smallest level among active lines.
- R9: Word 5 holds the grouping value in bits 2:0. A write takes effect only when bits 31:16 equal 0x05FA, and bits 31:16 read as 0xFA05.
- R10: Writing a line number into bits 7:0 of word 6 pends that line. A number not below the line count has no effect.
- R11: When `ack` is high and a line is selected, that line's pending bit clears and its active bit sets at the same edge. When `done` is high, the active bit of `done_line` clears.
- R12: Word 4 reads the active vector, and writes to it are ignored.
- R13: After reset all enable, pending, active, priority and grouping state is 0, and `pend_valid` and `preempt_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_in | input | NUM_LINES | Interrupt request inputs, sampled each clock |
| ack | input | 1 | Core activates the selected line |
| done | input | 1 | Core completes the line given by done_line |
| done_line | input | 5 | Line number being completed |
| pend_valid | output | 1 | A pending enabled line is selected |
| pend_vector | output | 9 | Vector number of the selected line |
| preempt_req | output | 1 | Selected line's level beats the running level |

## Verification
The bench builds the block with 8 lines and 3 priority bits. With that configuration every byte value can be written to every line and read back. The 8-entry priority space also makes ties frequent in pseudo-random selection sweeps. The grouping sweep covers all eight grouping values against every pair of running and candidate priorities. That sweep includes the settings where the 3 implemented bits are partly or wholly moved into the subpriority.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int MAX_LINES = 32;
    localparam int IDX_W = 5;
    localparam int VEC_W = 9;
    localparam logic [VEC_W-1:0] VEC_BASE = 9'd16;
    localparam logic [15:0] GRP_KEY_WR = 16'h05FA;
    localparam logic [15:0] GRP_KEY_RD = 16'hFA05;
    localparam int PRIO_BASE_WORD = 8;

    typedef enum logic [3:0] {
        W_EN_SET   = 4'd0,
        W_EN_CLR   = 4'd1,
        W_PEND_SET = 4'd2,
        W_PEND_CLR = 4'd3,
        W_ACTIVE   = 4'd4,
        W_GROUP    = 4'd5,
        W_TRIGGER  = 4'd6
    } reg_word_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [7:0]       prio;
    } pick_t;

    function automatic logic [7:0] group_mask(input logic [2:0] g);
        return 8'hFF << ({1'b0, g} + 4'd1);
    endfunction

    function automatic logic [7:0] group_of(input logic [7:0] prio, input logic [2:0] g);
        return prio & group_mask(g);
    endfunction

endpackage

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    input  logic [NUM_LINES-1:0]        irq_in,
    input  logic                        ack_fire,
    input  logic [IDX_W-1:0]            ack_idx,
    input  logic                        done_fire,
    input  logic [IDX_W-1:0]            done_idx,
    output logic [NUM_LINES-1:0]        en_q,
    output logic [NUM_LINES-1:0]        pend_q,
    output logic [NUM_LINES-1:0]        act_q,
    output logic [NUM_LINES-1:0][7:0]   prio_bytes,
    output logic [2:0]                  grp_q,
    output logic [31:0]                 rdata
);

    localparam int PRIO_WORDS = (NUM_LINES + 3) / 4;
    localparam int PAD_LINES  = PRIO_WORDS * 4;

    logic hit_en_set, hit_en_clr, hit_p_set, hit_p_clr, hit_grp, hit_trig;
    assign hit_en_set = wr_en && (addr == ADDR_W'(W_EN_SET));
    assign hit_en_clr = wr_en && (addr == ADDR_W'(W_EN_CLR));
    assign hit_p_set  = wr_en && (addr == ADDR_W'(W_PEND_SET));
    assign hit_p_clr  = wr_en && (addr == ADDR_W'(W_PEND_CLR));
    assign hit_grp    = wr_en && (addr == ADDR_W'(W_GROUP)) && (wdata[31:16] == GRP_KEY_WR);
    assign hit_trig   = wr_en && (addr == ADDR_W'(W_TRIGGER));

    logic [NUM_LINES-1:0] wmask, trig_mask, ack_mask, done_mask;
    logic [NUM_LINES-1:0] set_p, clr_p;
    assign wmask = wdata[NUM_LINES-1:0];

    logic [PRIO_BITS-1:0] prio_q [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign trig_mask[i] = hit_trig && (wdata[7:0] == 8'(i));
        assign ack_mask[i]  = ack_fire && (ack_idx == IDX_W'(i));
        assign done_mask[i] = done_fire && (done_idx == IDX_W'(i));
        assign prio_bytes[i] = 8'(prio_q[i]) << (8 - PRIO_BITS);

        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[i] <= '0;
            end else if (wr_en && addr == ADDR_W'(PRIO_BASE_WORD + i / 4)) begin
                prio_q[i] <= wdata[(i % 4) * 8 + 7 -: PRIO_BITS];
            end
        end
    end

    assign set_p = irq_in | (hit_p_set ? wmask : '0) | trig_mask;
    assign clr_p = (hit_p_clr ? wmask : '0) | ack_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            grp_q  <= '0;
        end else begin
            en_q   <= (en_q | (hit_en_set ? wmask : '0)) & ~(hit_en_clr ? wmask : '0);
            pend_q <= (pend_q | set_p) & ~clr_p;
            act_q  <= (act_q | ack_mask) & ~done_mask;
            if (hit_grp) grp_q <= wdata[2:0];
        end
    end

    logic [7:0]  byte_pad  [PAD_LINES];
    logic [31:0] prio_word [PRIO_WORDS];
    for (genvar p = 0; p < PAD_LINES; p++) begin : g_pad
        if (p < NUM_LINES) begin : g_real
            assign byte_pad[p] = prio_bytes[p];
        end else begin : g_zero
            assign byte_pad[p] = 8'h00;
        end
    end
    for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_word
        assign prio_word[w] = {byte_pad[w*4+3], byte_pad[w*4+2], byte_pad[w*4+1], byte_pad[w*4]};
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(W_EN_SET), ADDR_W'(W_EN_CLR):     rdata = 32'(en_q);
            ADDR_W'(W_PEND_SET), ADDR_W'(W_PEND_CLR): rdata = 32'(pend_q);
            ADDR_W'(W_ACTIVE):                        rdata = 32'(act_q);
            ADDR_W'(W_GROUP):                         rdata = {GRP_KEY_RD, 13'd0, grp_q};
            default: begin
                for (int w = 0; w < PRIO_WORDS; w++) begin
                    if (addr == ADDR_W'(PRIO_BASE_WORD + w)) rdata = prio_word[w];
                end
            end
        endcase
    end

    // R11
    ack_moves_line_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !done_fire) |=> ((act_q & $past(ack_mask)) == $past(ack_mask))
                                  && ((pend_q & $past(ack_mask)) == '0));

    // R12
    active_only_by_core_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_fire && !done_fire) |=> $stable(act_q));

    // R9
    group_key_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(W_GROUP) && wdata[31:16] != GRP_KEY_WR) |=> $stable(grp_q));

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_LINES-1:0]      cand,
    input  logic [NUM_LINES-1:0][7:0] prio_bytes,
    output pick_t                     pick
);

    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && (!pick.valid || prio_bytes[i] < pick.prio)) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
                pick.prio  = prio_bytes[i];
            end
        end
    end

    // R3
    pick_is_candidate_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> ((cand & (NUM_LINES'(1) << pick.idx)) != '0));

    // R7
    no_pick_without_cand_chk: assert property (@(posedge clk) disable iff (rst)
        !pick.valid |-> (cand == '0));

endmodule

// File: rtl/irq_running.sv
module irq_running
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_LINES-1:0]      act,
    input  logic [NUM_LINES-1:0][7:0] prio_bytes,
    input  logic [2:0]                grp,
    output logic                      run_valid,
    output logic [7:0]                run_group
);

    always_comb begin
        run_valid = 1'b0;
        run_group = 8'hFF;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (act[i] && (!run_valid || group_of(prio_bytes[i], grp) < run_group)) begin
                run_valid = 1'b1;
                run_group = group_of(prio_bytes[i], grp);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack,
    input  logic                 done,
    input  logic [IDX_W-1:0]     done_line,
    output logic                 pend_valid,
    output logic [VEC_W-1:0]     pend_vector,
    output logic                 preempt_req
);

    logic [NUM_LINES-1:0]      en_q, pend_q, act_q;
    logic [NUM_LINES-1:0][7:0] prio_bytes;
    logic [2:0]                grp_q;
    pick_t                     pick;
    logic                      run_valid;
    logic [7:0]                run_group;
    logic                      ack_fire;

    assign ack_fire = ack && pick.valid;

    irq_regbank #(
        .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .irq_in(irq_in),
        .ack_fire(ack_fire), .ack_idx(pick.idx),
        .done_fire(done), .done_idx(done_line),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q),
        .prio_bytes(prio_bytes), .grp_q(grp_q), .rdata(reg_rdata)
    );

    irq_select #(.NUM_LINES(NUM_LINES)) u_sel (
        .clk(clk), .rst(rst),
        .cand(pend_q & en_q), .prio_bytes(prio_bytes), .pick(pick)
    );

    irq_running #(.NUM_LINES(NUM_LINES)) u_run (
        .act(act_q), .prio_bytes(prio_bytes), .grp(grp_q),
        .run_valid(run_valid), .run_group(run_group)
    );

    assign pend_valid  = pick.valid;
    assign pend_vector = VEC_BASE + VEC_W'(pick.idx);
    assign preempt_req = pick.valid &&
                         (!run_valid || group_of(pick.prio, grp_q) < run_group);

    // R8
    preempt_needs_pick_chk: assert property (@(posedge clk) disable iff (rst)
        preempt_req |-> pend_valid);

    // R4
    active_survives_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> ((act_q & $past(act_q)) == $past(act_q)));

    // R13
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!pend_valid && !preempt_req));

endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

    localparam int NL = 8;
    localparam int PB = 3;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] irq_in = '0;
    logic          ack = 1'b0;
    logic          done = 1'b0;
    logic [4:0]    done_line = '0;
    logic          pend_valid;
    logic [8:0]    pend_vector;
    logic          preempt_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.NUM_LINES(NL), .PRIO_BITS(PB), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .ack(ack), .done(done), .done_line(done_line),
        .pend_valid(pend_valid), .pend_vector(pend_vector), .preempt_req(preempt_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_done(input int ln);
        @(negedge clk); done = 1'b1; done_line = 5'(ln);
        @(negedge clk); done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d, w0, w1, seed;
        logic [2:0]  pv [NL];
        logic [7:0]  pen, een, msk;
        int          best;
        logic        exp_pre;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        rd(0, d); chk("R13 enable", d, 0);
        rd(2, d); chk("R13 pending", d, 0);
        rd(4, d); chk("R13 active", d, 0);
        rd(5, d); chk("R13 group", d, 32'hFA050000);
        rd(8, d); chk("R13 prio0", d, 0);
        rd(9, d); chk("R13 prio1", d, 0);
        chk("R13 pend_valid", 32'(pend_valid), 0);
        chk("R13 preempt", 32'(preempt_req), 0);

        // R1 enable views
        wr(0, 32'hA5);
        rd(0, d); chk("R1 set view", d, 32'hA5);
        rd(1, d); chk("R1 clr view", d, 32'hA5);
        wr(0, 0);
        rd(0, d); chk("R1 zero set", d, 32'hA5);
        wr(1, 32'h05);
        rd(1, d); chk("R1 clear", d, 32'hA0);
        wr(1, 0);
        rd(0, d); chk("R1 zero clr", d, 32'hA0);
        wr(0, 32'hFFFFFFFF);
        rd(0, d); chk("R1 width", d, 32'hFF);
        wr(1, 32'hFF);

        // R2 pending views
        wr(2, 32'h3C);
        rd(2, d); chk("R2 set view", d, 32'h3C);
        rd(3, d); chk("R2 clr view", d, 32'h3C);
        wr(3, 32'h0C);
        rd(2, d); chk("R2 clear", d, 32'h30);
        wr(3, 32'hFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(3); reg_wdata = 32'h04; irq_in = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; irq_in = '0;
        rd(2, d); chk("R2 clear wins", d, 0);

        // R3 disabled line still pends
        @(negedge clk); irq_in = 8'h10;
        @(negedge clk); irq_in = '0;
        rd(2, d); chk("R3 latched", d, 32'h10);
        chk("R3 not selected", 32'(pend_valid), 0);
        wr(0, 32'h10);
        chk("R3 selected once enabled", 32'(pend_valid), 1);
        chk("R7 vector 20", 32'(pend_vector), 20);
        wr(3, 32'hFF); wr(1, 32'hFF);

        // R6 priority storage sweep
        for (int ln = 0; ln < NL; ln++) begin
            for (int v = 0; v < 256; v++) begin
                wr(8 + ln / 4, 32'(v) << (8 * (ln % 4)));
                rd(8 + ln / 4, d);
                chk("R6 prio readback", d, (32'(v) & 32'hE0) << (8 * (ln % 4)));
            end
        end

        // R7 selection sweep
        seed = 32'h1234_5678;
        for (int it = 0; it < 300; it++) begin
            for (int k = 0; k < NL; k++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                pv[k] = seed[18:16];
            end
            seed = seed * 32'd1103515245 + 32'd12345;
            pen = seed[23:16];
            seed = seed * 32'd1103515245 + 32'd12345;
            een = seed[23:16] | seed[31:24];
            for (int k = 0; k < 4; k++) begin
                w0[k*8 +: 8] = {pv[k], 5'b0};
                w1[k*8 +: 8] = {pv[k+4], 5'b0};
            end
            wr(8, w0); wr(9, w1);
            wr(3, 32'hFF); wr(2, 32'(pen));
            wr(1, 32'hFF); wr(0, 32'(een));
            best = -1;
            for (int k = 0; k < NL; k++) begin
                if (pen[k] && een[k] && (best < 0 || pv[k] < pv[best])) best = k;
            end
            chk("R7 valid", 32'(pend_valid), 32'(best >= 0));
            if (best >= 0) chk("R7 vector", 32'(pend_vector), 32'(best + 16));
            chk("R8 idle preempt", 32'(preempt_req), 32'(best >= 0));
        end
        wr(3, 32'hFF); wr(1, 32'hFF);

        // R10 software trigger
        for (int ln = 0; ln < NL; ln++) begin
            wr(6, 32'(ln));
            rd(2, d); chk("R10 trigger", d, 32'(1) << ln);
            wr(3, 32'hFF);
        end
        wr(6, 32'd8);
        rd(2, d); chk("R10 out of range 8", d, 0);
        wr(6, 32'd200);
        rd(2, d); chk("R10 out of range 200", d, 0);

        // R8 grouping sweep with R11 ack/done
        wr(0, 32'h03);
        for (int g = 0; g < 8; g++) begin
            wr(5, {16'h05FA, 13'd0, 3'(g)});
            rd(5, d); chk("R9 keyed write", d, {16'hFA05, 13'd0, 3'(g)});
            msk = 8'hFF << (g + 1);
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    wr(8, (32'(b) << 13) | (32'(a) << 5));
                    wr(2, 32'h01);
                    pulse_ack();
                    rd(4, d); chk("R11 active set", d, 32'h01);
                    rd(2, d); chk("R11 pending cleared", d, 0);
                    wr(2, 32'h02);
                    exp_pre = ((8'(b) << 5) & msk) < ((8'(a) << 5) & msk);
                    chk("R8 preempt", 32'(preempt_req), 32'(exp_pre));
                    chk("R7 vector 17", 32'(pend_vector), 17);
                    pulse_done(0);
                    rd(4, d); chk("R11 done clears", d, 0);
                    wr(3, 32'h02);
                end
            end
        end

        // R9 bad key ignored
        wr(5, 32'h1234_0002);
        rd(5, d); chk("R9 bad key", d, 32'hFA050007);

        // R4, R5, R12 on an active line
        wr(1, 32'hFF);
        wr(0, 32'h08); wr(2, 32'h08);
        pulse_ack();
        rd(4, d); chk("R11 line3 active", d, 32'h08);
        wr(1, 32'h08);
        rd(4, d); chk("R4 active kept", d, 32'h08);
        rd(0, d); chk("R4 enable cleared", d, 0);
        wr(3, 32'h08);
        rd(4, d); chk("R5 active kept", d, 32'h08);
        wr(4, 32'h00);
        rd(4, d); chk("R12 write zero", d, 32'h08);
        wr(4, 32'hFF);
        rd(4, d); chk("R12 write ones", d, 32'h08);
        pulse_done(3);
        rd(4, d); chk("R11 line3 done", d, 0);

        finish_run();
    end

endmodule